// File: doc/BRIEF.md
# Match-Capture Timer Counter

This block is a general-purpose timer/counter with a register port made of a write strobe, a read strobe, a word address and 32-bit data. It can run in two modes. In timer mode it counts clock cycles divided down by a programmable prescaler. In counter mode it counts rising, falling or both edges on one of its capture inputs. Four compare channels watch the running count. On a hit, each channel can raise an interrupt flag, send the count back to zero, or halt it. Each channel also drives an output pin that a hit can leave alone, force low, force high or toggle.

Two capture channels copy the running count into their own registers when a chosen edge arrives on their input. Both capture inputs first pass through a two-flop synchroniser and an edge detector. Every match and capture event can set a bit in a single flag register. Software clears a flag by writing a one to it. One interrupt line reports whether any flag is set.

The count width, the prescaler width and the number of match and capture channels are parameters. They are checked at elaboration. The bit positions inside each control register stay fixed, whatever the channel count.

Top module: `mct_timer`

## Requirements
- R1: After reset, every register reads zero, `match_out` is all zero and `irq` is low.
- R2: The word addresses are fixed:
  - 0: control
  - 1: prescale limit
  - 2: prescale count (read only)
  - 3: main count (read only)
  - 4: count mode
  - 5: match control
  - 6: capture control
  - 7: match output
  - 8: flags
  - 9 to 12: match values 0 to 3
  - 13 and 14: captured values 0 and 1 (read only)

  In the control register, bit 0 is run enable and bit 1 is hold-in-reset. These are the only writable bits; all other bits read as zero. `rd_data` is zero while `rd_en` is low.
- R3: While hold-in-reset is set, the main count and the prescale count stay at zero, whether or not run enable is set.
- R4: In timer mode (count mode bits [1:0] = 0) with run enable set, the main count advances by one every prescale-limit-plus-one clock cycles.
- R5: A hit on match channel n occurs on a count step taken while the main count equals match value n. If match control bit 3n is set, the hit sets flag bit n.
- R6: If match control bit 3n+1 is set, a hit on channel n loads zero into the main count in place of the increment, and the prescale count also restarts from zero.
- R7: If match control bit 3n+2 is set, a hit on channel n clears run enable and leaves the main count unchanged. Without bit 3n the hit sets no flag.
- R8: In the match output register, bit n is the current level of `match_out[n]`. Bits 2n+5:2n+4 select the action taken on a hit of channel n: 0 no change, 1 drive low, 2 drive high, 3 toggle.
- R9: Count mode bits [1:0] set to 1, 2 or 3 make the main count step on rising, falling or both edges of one synchronised capture input. Bits [3:2] select that input: 0 picks input 0, 1 picks input 1. The other input has no effect on the count.
- R10: Capture control bits 3n, 3n+1 and 3n+2 enable, for channel n, capture on a rising edge, capture on a falling edge, and flag on capture. An enabled edge copies the main count into captured value n and, if bit 3n+2 is set, sets flag bit 4+n. A channel with both edge bits clear never captures.
- R11: Writing flags with a one in a bit clears that flag. If a new event sets the same flag in the same cycle, the flag stays set.
- R12: `irq` is high exactly when at least one flag bit is set.
- R13: The main count wraps from its all-ones value to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, zero-extended, combinational |
| cap_in | input | N_CAP | Asynchronous capture / count inputs |
| match_out | output | N_MATCH | Match output levels |
| irq | output | 1 | OR of all flag bits |

## Verification
The bench builds the block with an 8-bit main count and an 8-bit prescaler, keeping four match channels and two capture channels. The narrow count lets the wrap from 255 to zero happen within a few hundred cycles. The narrow width also keeps exact cycle counting practical for the prescaler, for reset-on-match periods and for the set-wins-over-clear collision. Capture values are predicted from the synchroniser latency, so a capture is expected to hold the count two cycles after the edge has been registered.

// File: rtl/mct_pkg.sv
package mct_pkg;

   // register word addresses
   localparam logic [3:0] A_CTRL   = 4'd0;
   localparam logic [3:0] A_PRE    = 4'd1;
   localparam logic [3:0] A_PCNT   = 4'd2;
   localparam logic [3:0] A_TCNT   = 4'd3;
   localparam logic [3:0] A_CMODE  = 4'd4;
   localparam logic [3:0] A_MCTL   = 4'd5;
   localparam logic [3:0] A_CCTL   = 4'd6;
   localparam logic [3:0] A_MOUT   = 4'd7;
   localparam logic [3:0] A_FLAG   = 4'd8;
   localparam logic [3:0] A_MVAL0  = 4'd9;
   localparam logic [3:0] A_CVAL0  = 4'd13;

   // flag bit where capture flags start
   localparam int unsigned CAP_FLAG_BASE = 4;
   // bit where match output actions start
   localparam int unsigned ACT_BASE = 4;

   typedef enum logic [1:0] {
      ACT_KEEP   = 2'd0,
      ACT_LOW    = 2'd1,
      ACT_HIGH   = 2'd2,
      ACT_TOGGLE = 2'd3
   } out_act_e;

   typedef enum logic [1:0] {
      MODE_TIMER = 2'd0,
      MODE_RISE  = 2'd1,
      MODE_FALL  = 2'd2,
      MODE_BOTH  = 2'd3
   } cnt_mode_e;

endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);

   logic [N-1:0] meta_q, sync_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
         prev_q <= '0;
      end else begin
         meta_q <= din;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign rise = sync_q & ~prev_q;
   assign fall = ~sync_q & prev_q;

endmodule

// File: rtl/mct_match_unit.sv
module mct_match_unit
   import mct_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] target,
   input  logic             step,
   input  out_act_e         act,
   input  logic             sw_we,
   input  logic             sw_level,
   output logic             hit,
   output logic             level
);

   assign hit = step && (count == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level <= 1'b0;
      end else if (hit && act != ACT_KEEP) begin
         unique case (act)
            ACT_LOW:    level <= 1'b0;
            ACT_HIGH:   level <= 1'b1;
            ACT_TOGGLE: level <= ~level;
            default:    level <= level;
         endcase
      end else if (sw_we) begin
         level <= sw_level;
      end
   end

endmodule

// File: rtl/mct_capture_unit.sv
module mct_capture_unit #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   input  logic             fall,
   input  logic             on_rise,
   input  logic             on_fall,
   input  logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] held,
   output logic             event_o
);

   assign event_o = (rise && on_rise) || (fall && on_fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held <= '0;
      else if (event_o)
         held <= count;
   end

endmodule

// File: rtl/mct_timer.sv
module mct_timer
   import mct_pkg::*;
#(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned PS_W    = 32,
   parameter int unsigned N_MATCH = 4,
   parameter int unsigned N_CAP   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [3:0]         addr,
   input  logic [31:0]        wr_data,
   output logic [31:0]        rd_data,
   input  logic [N_CAP-1:0]   cap_in,
   output logic [N_MATCH-1:0] match_out,
   output logic               irq
);

   localparam int unsigned MCR_W  = 3 * N_MATCH;
   localparam int unsigned CCR_W  = 3 * N_CAP;
   localparam int unsigned ACT_W  = 2 * N_MATCH;
   localparam int unsigned FLAG_W = CAP_FLAG_BASE + N_CAP;
   localparam logic [CNT_W-1:0] TC_ONE = CNT_W'(1);
   localparam logic [PS_W-1:0]  PC_ONE = PS_W'(1);

   initial begin
      assert (CNT_W >= 2 && CNT_W <= 32) else $error("CNT_W out of range");
      assert (PS_W >= 1 && PS_W <= 32) else $error("PS_W out of range");
      assert (N_MATCH >= 1 && N_MATCH <= 4) else $error("N_MATCH out of range");
      assert (N_CAP >= 1 && N_CAP <= 2) else $error("N_CAP out of range");
   end

   // ---------------- register state ----------------
   logic                          ctrl_en, ctrl_rst;
   logic [PS_W-1:0]               pr_q, pc_q;
   logic [CNT_W-1:0]              tc_q;
   cnt_mode_e                     mode_q;
   logic                          src_q;
   logic [MCR_W-1:0]              mcr_q;
   logic [CCR_W-1:0]              ccr_q;
   logic [ACT_W-1:0]              act_q;
   logic [FLAG_W-1:0]             flags_q;
   logic [N_MATCH-1:0][CNT_W-1:0] mv_q;
   logic [CNT_W-1:0]              cap_val [N_CAP];

   // ---------------- write decode ----------------
   logic wr_ctrl, wr_pre, wr_mode, wr_mctl, wr_cctl, wr_mout, wr_flag;
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign wr_pre  = wr_en && (addr == A_PRE);
   assign wr_mode = wr_en && (addr == A_CMODE);
   assign wr_mctl = wr_en && (addr == A_MCTL);
   assign wr_cctl = wr_en && (addr == A_CCTL);
   assign wr_mout = wr_en && (addr == A_MOUT);
   assign wr_flag = wr_en && (addr == A_FLAG);

   // ---------------- input edges ----------------
   logic [N_CAP-1:0] cap_rise, cap_fall;
   logic             src_rise, src_fall;

   mct_edge_sync #(.N(N_CAP)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cap_in),
      .rise (cap_rise),
      .fall (cap_fall)
   );

   if (N_CAP > 1) begin : g_src_sel
      assign src_rise = src_q ? cap_rise[1] : cap_rise[0];
      assign src_fall = src_q ? cap_fall[1] : cap_fall[0];
   end else begin : g_src_one
      assign src_rise = cap_rise[0];
      assign src_fall = cap_fall[0];
   end

   // ---------------- count step ----------------
   logic run, pre_wrap, edge_step, tick;
   assign run      = ctrl_en && !ctrl_rst;
   assign pre_wrap = (pc_q == pr_q);

   always_comb begin
      unique case (mode_q)
         MODE_RISE: edge_step = src_rise;
         MODE_FALL: edge_step = src_fall;
         MODE_BOTH: edge_step = src_rise || src_fall;
         default:   edge_step = 1'b0;
      endcase
   end

   assign tick = run && ((mode_q == MODE_TIMER) ? pre_wrap : edge_step);

   // ---------------- match channels ----------------
   logic [N_MATCH-1:0] hit, m_int, m_rst, m_stop;
   logic               rst_hit, stop_hit;

   for (genvar n = 0; n < N_MATCH; n++) begin : g_mch
      assign m_int[n]  = mcr_q[3*n];
      assign m_rst[n]  = mcr_q[3*n+1];
      assign m_stop[n] = mcr_q[3*n+2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mv_q[n] <= '0;
         else if (wr_en && addr == A_MVAL0 + 4'(n))
            mv_q[n] <= wr_data[CNT_W-1:0];
      end

      mct_match_unit #(.CNT_W(CNT_W)) u_match (
         .clk     (clk),
         .rst_n   (rst_n),
         .count   (tc_q),
         .target  (mv_q[n]),
         .step    (tick),
         .act     (out_act_e'(act_q[2*n +: 2])),
         .sw_we   (wr_mout),
         .sw_level(wr_data[n]),
         .hit     (hit[n]),
         .level   (match_out[n])
      );
   end

   assign rst_hit  = |(hit & m_rst);
   assign stop_hit = |(hit & m_stop);

   // ---------------- capture channels ----------------
   logic [N_CAP-1:0] cap_ev, c_int;

   for (genvar c = 0; c < N_CAP; c++) begin : g_cch
      assign c_int[c] = ccr_q[3*c+2];

      mct_capture_unit #(.CNT_W(CNT_W)) u_cap (
         .clk    (clk),
         .rst_n  (rst_n),
         .rise   (cap_rise[c]),
         .fall   (cap_fall[c]),
         .on_rise(ccr_q[3*c]),
         .on_fall(ccr_q[3*c+1]),
         .count  (tc_q),
         .held   (cap_val[c]),
         .event_o(cap_ev[c])
      );
   end

   // ---------------- flags ----------------
   logic [FLAG_W-1:0] flag_set, flag_clr;

   always_comb begin
      flag_set = '0;
      for (int n = 0; n < N_MATCH; n++)
         flag_set[n] = hit[n] && m_int[n];
      for (int c = 0; c < N_CAP; c++)
         flag_set[CAP_FLAG_BASE + c] = cap_ev[c] && c_int[c];
   end

   assign flag_clr = wr_flag ? wr_data[FLAG_W-1:0] : '0;
   assign irq      = |flags_q;

   // ---------------- sequential state ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         ctrl_rst <= 1'b0;
         pr_q <= '0;
         mode_q <= MODE_TIMER;
         src_q <= 1'b0;
         mcr_q <= '0;
         ccr_q <= '0;
         act_q <= '0;
         flags_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en  <= wr_data[0];
            ctrl_rst <= wr_data[1];
         end
         if (tick && stop_hit)
            ctrl_en <= 1'b0;
         if (wr_pre)  pr_q <= wr_data[PS_W-1:0];
         if (wr_mode) begin
            mode_q <= cnt_mode_e'(wr_data[1:0]);
            src_q  <= wr_data[2];
         end
         if (wr_mctl) mcr_q <= wr_data[MCR_W-1:0];
         if (wr_cctl) ccr_q <= wr_data[CCR_W-1:0];
         if (wr_mout) act_q <= wr_data[ACT_BASE +: ACT_W];
         flags_q <= (flags_q & ~flag_clr) | flag_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
         tc_q <= '0;
      end else if (ctrl_rst) begin
         pc_q <= '0;
         tc_q <= '0;
      end else begin
         if (run && mode_q == MODE_TIMER)
            pc_q <= pre_wrap ? '0 : pc_q + PC_ONE;
         else if (mode_q != MODE_TIMER)
            pc_q <= '0;
         if (tick) begin
            if (rst_hit)
               tc_q <= '0;
            else if (!stop_hit)
               tc_q <= tc_q + TC_ONE;
         end
      end
   end

   // ---------------- read mux ----------------
   logic [31:0] rdv;

   always_comb begin
      rdv = '0;
      unique case (addr)
         A_CTRL:  rdv[1:0] = {ctrl_rst, ctrl_en};
         A_PRE:   rdv[PS_W-1:0] = pr_q;
         A_PCNT:  rdv[PS_W-1:0] = pc_q;
         A_TCNT:  rdv[CNT_W-1:0] = tc_q;
         A_CMODE: rdv[3:0] = {1'b0, src_q, mode_q};
         A_MCTL:  rdv[MCR_W-1:0] = mcr_q;
         A_CCTL:  rdv[CCR_W-1:0] = ccr_q;
         A_MOUT: begin
            rdv[N_MATCH-1:0] = match_out;
            rdv[ACT_BASE +: ACT_W] = act_q;
         end
         A_FLAG:  rdv[FLAG_W-1:0] = flags_q;
         default: begin
            for (int n = 0; n < N_MATCH; n++)
               if (addr == A_MVAL0 + 4'(n)) rdv[CNT_W-1:0] = mv_q[n];
            for (int c = 0; c < N_CAP; c++)
               if (addr == A_CVAL0 + 4'(c)) rdv[CNT_W-1:0] = cap_val[c];
         end
      endcase
   end

   assign rd_data = rd_en ? rdv : '0;

endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PS_W   = 32,
   parameter int unsigned FLAG_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [FLAG_W-1:0] flags_q,
   input logic [FLAG_W-1:0] flag_set,
   input logic              ctrl_en,
   input logic              ctrl_rst,
   input logic [CNT_W-1:0]  tc_q,
   input logic [PS_W-1:0]   pc_q,
   input logic              tick,
   input logic              rst_hit,
   input logic              stop_hit,
   input logic              wr_en,
   input logic [3:0]        addr,
   input logic [1:0]        ctrl_wd,
   input logic [1:0]        ccr_lo,
   input logic [CNT_W-1:0]  cap0
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_irq_is_or_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (flags_q != '0));

   assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rst |=> (tc_q == '0 && pc_q == '0));

   assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_q != $past(tc_q)) |-> (tc_q == $past(tc_q) + ONE || tc_q == '0));

   assert_reset_on_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && rst_hit) |=> (tc_q == '0));

   assert_stop_clears_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && stop_hit) |=> !ctrl_en);

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_set != '0) |=> ((flags_q & $past(flag_set)) == $past(flag_set)));

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 4'd0 && !(tick && stop_hit)) |=>
         ({ctrl_rst, ctrl_en} == $past(ctrl_wd)));

   assert_no_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ccr_lo == 2'b00) |=> (cap0 == $past(cap0)));

endmodule

bind mct_timer mct_timer_chk #(
   .CNT_W (CNT_W),
   .PS_W  (PS_W),
   .FLAG_W(FLAG_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .irq     (irq),
   .flags_q (flags_q),
   .flag_set(flag_set),
   .ctrl_en (ctrl_en),
   .ctrl_rst(ctrl_rst),
   .tc_q    (tc_q),
   .pc_q    (pc_q),
   .tick    (tick),
   .rst_hit (rst_hit),
   .stop_hit(stop_hit),
   .wr_en   (wr_en),
   .addr    (addr),
   .ctrl_wd (wr_data[1:0]),
   .ccr_lo  (ccr_q[1:0]),
   .cap0    (cap_val[0])
);

// File: tb/mct_timer_test.sv
module mct_timer_test;

   localparam int unsigned CNT_W = 8;
   localparam int unsigned PS_W  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  cap_in = '0;
   logic [3:0]  match_out;
   logic        irq;

   int checks = 0;
   int errors = 0;

   mct_timer #(.CNT_W(CNT_W), .PS_W(PS_W), .N_MATCH(4), .N_CAP(2)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .cap_in(cap_in),
      .match_out(match_out), .irq(irq)
   );

   always #2 clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      addr = a; rd_en = 1'b1;
      #1 v = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, exp);
   endtask

   task automatic pulse(input int ch);
      cap_in[ch] = 1'b1; cyc(4);
      cap_in[ch] = 1'b0; cyc(4);
   endtask

   task automatic restart();
      wr(4'd0, 32'h2);
      wr(4'd5, 32'h0);
      wr(4'd6, 32'h0);
      wr(4'd7, 32'h0);
      wr(4'd4, 32'h0);
      wr(4'd1, 32'h0);
      wr(4'd8, 32'h3F);
   endtask

   task automatic t_reset_state();
      for (int a = 0; a < 15; a++)
         rd_check("R1 register reset value", 4'(a), 32'h0);
      check("R1 match_out reset", 32'(match_out), 32'h0);
      check("R1 irq reset", 32'(irq), 32'h0);
      addr = 4'd0; rd_en = 1'b0; #1;
      check("R2 rd_data idle", rd_data, 32'h0);
   endtask

   task automatic t_ctrl_bits();
      wr(4'd0, 32'hFFFF_FFFC);
      rd_check("R2 only low bits writable", 4'd0, 32'h0);
      wr(4'd0, 32'h2);
      rd_check("R2 control readback", 4'd0, 32'h2);
      wr(4'd1, 32'h5A);
      rd_check("R2 prescale readback", 4'd1, 32'h5A);
   endtask

   task automatic t_hold_reset();
      restart();
      wr(4'd1, 32'd2);
      wr(4'd0, 32'h3);
      cyc(10);
      rd_check("R3 count held at zero", 4'd3, 32'h0);
      rd_check("R3 prescale held at zero", 4'd2, 32'h0);
      wr(4'd0, 32'h1);
      cyc(3);
      rd_check("R3 counting resumes", 4'd3, 32'd1);
   endtask

   task automatic t_prescale();
      restart();
      wr(4'd1, 32'd3);
      wr(4'd0, 32'h1);
      cyc(20);
      rd_check("R4 one step per four cycles", 4'd3, 32'd5);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_match_flag();
      logic [31:0] v;
      restart();
      wr(4'd9, 32'd4);
      wr(4'd5, 32'h3);
      wr(4'd0, 32'h1);
      cyc(5);
      rd_check("R6 count reset on hit", 4'd3, 32'd0);
      rd_check("R5 match flag set", 4'd8, 32'h01);
      check("R12 irq high with flag", 32'(irq), 32'h1);
      cyc(1);
      wr(4'd8, 32'h01);
      rd(4'd8, v);
      check("R11 write one clears", v, 32'h0);
      check("R12 irq low when clear", 32'(irq), 32'h0);
      cyc(2);
      rd_check("R6 count before hit", 4'd3, 32'd4);
      wr(4'd8, 32'h01);
      rd_check("R11 set wins over clear", 4'd8, 32'h01);
      rd_check("R6 period restarts", 4'd3, 32'd0);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_stop();
      restart();
      wr(4'd10, 32'd3);
      wr(4'd5, 32'h20);
      wr(4'd0, 32'h1);
      cyc(12);
      rd_check("R7 count holds at match", 4'd3, 32'd3);
      rd_check("R7 enable cleared", 4'd0, 32'h0);
      rd_check("R7 no flag without int bit", 4'd8, 32'h0);
   endtask

   task automatic t_outputs();
      restart();
      wr(4'd9, 32'd2);
      wr(4'd10, 32'd1);
      wr(4'd11, 32'd2);
      wr(4'd12, 32'd0);
      wr(4'd5, 32'h2);
      wr(4'd7, 32'h1BC);
      check("R8 software level write", 32'(match_out), 32'hC);
      wr(4'd0, 32'h1);
      cyc(3);
      check("R8 toggle high low actions", 32'(match_out), 32'hB);
      cyc(3);
      check("R8 second toggle", 32'(match_out), 32'hA);
      rd_check("R8 register readback", 4'd7, 32'h1BA);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_counter_mode();
      restart();
      wr(4'd4, 32'h1);
      wr(4'd0, 32'h1);
      pulse(0); pulse(0); pulse(0);
      rd_check("R9 rising edges input 0", 4'd3, 32'd3);
      pulse(1);
      rd_check("R9 other input ignored", 4'd3, 32'd3);
      wr(4'd4, 32'h7);
      pulse(1); pulse(1);
      rd_check("R9 both edges input 1", 4'd3, 32'd7);
      pulse(0);
      rd_check("R9 input 0 ignored", 4'd3, 32'd7);
      wr(4'd4, 32'h2);
      pulse(0);
      rd_check("R9 falling edge input 0", 4'd3, 32'd8);
      wr(4'd0, 32'h0);
   endtask

   task automatic t_capture();
      logic [31:0] t;
      restart();
      wr(4'd6, 32'h05);
      wr(4'd0, 32'h1);
      cyc(4);
      cap_in = 2'b11;
      cyc(6);
      rd_check("R10 rising capture value", 4'd13, 32'd6);
      rd_check("R10 unconfigured channel", 4'd14, 32'd0);
      rd_check("R10 capture flag", 4'd8, 32'h10);
      cap_in = 2'b00;
      cyc(5);
      rd_check("R10 fall ignored when rise only", 4'd13, 32'd6);
      wr(4'd0, 32'h0);
      rd(4'd3, t);
      wr(4'd6, 32'h1B);
      cap_in[1] = 1'b1;
      cyc(5);
      rd_check("R10 both edge capture", 4'd14, t);
      rd_check("R10 no flag without int bit", 4'd8, 32'h10);
   endtask

   task automatic t_wrap();
      restart();
      wr(4'd0, 32'h1);
      cyc(255);
      rd_check("R13 all ones", 4'd3, 32'd255);
      cyc(1);
      rd_check("R13 wraps to zero", 4'd3, 32'd0);
      wr(4'd0, 32'h0);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      t_reset_state();
      t_ctrl_bits();
      t_hold_reset();
      t_prescale();
      t_match_flag();
      t_stop();
      t_outputs();
      t_counter_mode();
      t_capture();
      t_wrap();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule